// File: doc/BRIEF.md
# USB SETUP Packet Capture FIFO

This block sits beside a USB device protocol engine and takes in the SETUP transactions the engine hands over for any endpoint. When the engine reports a SETUP token, the block records the endpoint number and collects the following data packet. It keeps the eight request bytes and drops the two trailing CRC bytes. It acknowledges every such packet unconditionally and never applies flow control. A CPU reaches the captured request through a small byte-wide register bus. It reads a status word, pops the request one byte per read, and can flush the buffer. An event flag, which can be masked, drives an interrupt line when a new request lands. The block also keeps the device address that firmware programs after address assignment. A USB bus reset returns that address to zero.

Capture is sequenced by a five-state controller:
- CAP_IDLE: waits for a SETUP token.
- CAP_ARMED: the token is seen and the first data byte is awaited.
- CAP_FILL: payload bytes are being stored.
- CAP_TAIL: the eight payload bytes are held and further bytes are discarded until the last one.
- CAP_ACK: a one-cycle state that raises the acknowledge and commits the packet.

The transitions are as follows:
- IDLE→ARMED on a token.
- ARMED→FILL on a non-final byte.
- ARMED→ACK on a final byte.
- FILL→TAIL when the eighth byte is stored and it is not final.
- FILL→ACK on a final byte.
- TAIL→ACK on the final byte.
- ACK→IDLE always.
- Any state→ARMED on a new token.
- Any state→IDLE on a bus reset or flush. These take priority over the token.

Top module: `setup_capture`

## Requirements
- R1: ack_o is high for exactly one cycle, the cycle after the final data byte (rx_last) of a packet that followed a SETUP token. This holds whether or not earlier data is still unread or the event is still pending.
- R2: A write to offset 0 loads csr_wdata[7:0] into the device address, and a read of offset 0 returns it. A usb_reset pulse returns the address to 0.
- R3: A read of offset 1 returns the status word: address in [7:0], endpoint of the last committed SETUP in [11:8], data-available flag in [12], and zeros above. The status word is all zero after reset.
- R4: Each read of offset 3 while data is available returns the next stored byte in [7:0], in arrival order, and advances the buffer.
- R5: Only the first eight data bytes of a packet are stored and the two CRC bytes that follow are discarded. The data-available flag falls after exactly eight reads.
- R6: A new SETUP packet replaces any unread bytes of the previous one, and the status endpoint field shows the new endpoint.
- R7: A write to offset 2 with bit 0 set empties the buffer and clears the endpoint field and the data-available flag. A write with bit 0 clear has no effect.
- R8: A committed packet sets the pending flag, read at offset 5 bit 0. Writing 1 to that bit clears it, and a commit in the same cycle wins. The enable bit is at offset 4 bit 0. irq_o is pending AND enable.
- R9: A read of offset 3 while no data is available returns 0 and does not move the read position. This includes reads made while a packet is still being received.
- R10: A usb_reset during reception abandons the packet: there is no acknowledge, no data becomes available and the pending flag is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| usb_reset | input | 1 | Bus reset seen by the device core (one-cycle pulse) |
| tok_setup | input | 1 | SETUP token received (one-cycle pulse) |
| tok_ep | input | 4 | Endpoint number of the token |
| rx_valid | input | 1 | Received data byte valid |
| rx_data | input | 8 | Received data byte |
| rx_last | input | 1 | Marks the final byte of the data packet |
| ack_o | output | 1 | Request to send an ACK handshake |
| csr_addr | input | 3 | Register offset |
| csr_wr | input | 1 | Register write strobe |
| csr_rd | input | 1 | Register read strobe (pops on the data offset) |
| csr_wdata | input | 8 | Register write data |
| csr_rdata | output | 16 | Register read data, combinational on csr_addr |
| irq_o | output | 1 | Interrupt: pending AND enable |

## Verification
The assertions rely on several properties of the inputs. Every SETUP data packet carries exactly eight payload bytes followed by two CRC bytes. rx_last is only ever raised together with rx_valid. Tokens, bus resets and flushes are single-cycle pulses, and the CPU never reads and writes in the same cycle. The stimulus honours this by sending every packet through one driver task that always emits ten bytes. The only deliberate deviations are a bus reset and a CPU data read made in the middle of reception; both are legal inputs whose outcome the requirements define.

// File: rtl/setup_cap_pkg.sv
package setup_cap_pkg;

    typedef enum logic [2:0] {
        CAP_IDLE  = 3'd0,
        CAP_ARMED = 3'd1,
        CAP_FILL  = 3'd2,
        CAP_TAIL  = 3'd3,
        CAP_ACK   = 3'd4
    } cap_state_t;

    localparam int unsigned CSR_AW = 3;

    localparam logic [CSR_AW-1:0] OFS_ADDR   = 3'd0;
    localparam logic [CSR_AW-1:0] OFS_STATUS = 3'd1;
    localparam logic [CSR_AW-1:0] OFS_FLUSH  = 3'd2;
    localparam logic [CSR_AW-1:0] OFS_DATA   = 3'd3;
    localparam logic [CSR_AW-1:0] OFS_IRQEN  = 3'd4;
    localparam logic [CSR_AW-1:0] OFS_IRQPND = 3'd5;

endpackage

// File: rtl/setup_byte_fifo.sv
// Linear byte buffer refilled once per packet; cleared before each capture.
module setup_byte_fifo #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned WIDTH = 8,
    localparam int unsigned PW   = $clog2(DEPTH + 1),
    localparam int unsigned IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head_data,
    output logic [PW-1:0]    level,
    output logic             empty,
    output logic             full
);

    logic [PW-1:0]    wr_ptr;
    logic [PW-1:0]    rd_ptr;
    logic [WIDTH-1:0] slot [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
        end else if (push && !full) begin
            wr_ptr <= wr_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
        end else if (clr) begin
            rd_ptr <= '0;
        end else if (pop && !empty) begin
            rd_ptr <= rd_ptr + 1'b1;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot[g] <= '0;
            end else if (push && !full && !clr && (wr_ptr == PW'(g))) begin
                slot[g] <= push_data;
            end
        end
    end

    assign empty     = (rd_ptr == wr_ptr);
    assign full      = (wr_ptr == PW'(DEPTH));
    assign level     = wr_ptr - rd_ptr;
    assign head_data = empty ? '0 : slot[rd_ptr[IW-1:0]];

endmodule

// File: rtl/setup_cap_fsm.sv
module setup_cap_fsm
    import setup_cap_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned EPW   = 4,
    localparam int unsigned PW   = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_rst,
    input  logic           flush,
    input  logic           tok_setup,
    input  logic [EPW-1:0] tok_ep,
    input  logic           rx_valid,
    input  logic           rx_last,
    input  logic [PW-1:0]  fifo_wcount,
    input  logic           fifo_full,
    output logic           fifo_clr,
    output logic           push,
    output logic           ack,
    output logic           commit,
    output logic           committed,
    output logic [EPW-1:0] last_ep
);

    cap_state_t     state, state_nxt;
    logic [EPW-1:0] arm_ep;
    logic           abort;
    logic           final_slot;

    assign abort      = bus_rst || flush;
    assign final_slot = (fifo_wcount == PW'(DEPTH - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CAP_IDLE;
        else        state <= state_nxt;
    end

    // transitions
    always_comb begin
        state_nxt = state;
        if (abort) begin
            state_nxt = CAP_IDLE;
        end else if (tok_setup) begin
            state_nxt = CAP_ARMED;
        end else begin
            unique case (state)
                CAP_IDLE:  state_nxt = CAP_IDLE;
                CAP_ARMED: begin
                    if (rx_valid) state_nxt = rx_last ? CAP_ACK : CAP_FILL;
                end
                CAP_FILL: begin
                    if (rx_valid && rx_last)         state_nxt = CAP_ACK;
                    else if (rx_valid && final_slot) state_nxt = CAP_TAIL;
                end
                CAP_TAIL: begin
                    if (rx_valid && rx_last) state_nxt = CAP_ACK;
                end
                CAP_ACK:   state_nxt = CAP_IDLE;
                default:   state_nxt = CAP_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        fifo_clr = abort || tok_setup;
        push     = 1'b0;
        ack      = 1'b0;
        unique case (state)
            CAP_ARMED, CAP_FILL: push = rx_valid && !fifo_full && !fifo_clr;
            CAP_ACK:             ack  = 1'b1;
            CAP_IDLE, CAP_TAIL:  push = 1'b0;
            default:             push = 1'b0;
        endcase
        commit = ack && !fifo_clr;
    end

    // packet bookkeeping: endpoint armed by token, published at commit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arm_ep    <= '0;
            last_ep   <= '0;
            committed <= 1'b0;
        end else if (abort) begin
            arm_ep    <= '0;
            last_ep   <= '0;
            committed <= 1'b0;
        end else if (tok_setup) begin
            arm_ep    <= tok_ep;
            committed <= 1'b0;
        end else if (commit) begin
            last_ep   <= arm_ep;
            committed <= 1'b1;
        end
    end

endmodule

// File: rtl/setup_cap_regs.sv
module setup_cap_regs
    import setup_cap_pkg::*;
#(
    parameter int unsigned EPW = 4,
    parameter int unsigned AW  = 8,
    parameter int unsigned RW  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rst,
    input  logic [CSR_AW-1:0] csr_addr,
    input  logic              csr_wr,
    input  logic              csr_rd,
    input  logic [7:0]        csr_wdata,
    input  logic              commit,
    input  logic              have,
    input  logic [EPW-1:0]    last_ep,
    input  logic [7:0]        head_data,
    output logic [AW-1:0]     dev_addr,
    output logic              irq_en,
    output logic              irq_pend,
    output logic              flush,
    output logic              pop,
    output logic [RW-1:0]     csr_rdata,
    output logic              irq
);

    logic wr_addr, wr_en, wr_pend;

    assign wr_addr = csr_wr && (csr_addr == OFS_ADDR);
    assign wr_en   = csr_wr && (csr_addr == OFS_IRQEN);
    assign wr_pend = csr_wr && (csr_addr == OFS_IRQPND) && csr_wdata[0];
    assign flush   = csr_wr && (csr_addr == OFS_FLUSH) && csr_wdata[0];
    assign pop     = csr_rd && (csr_addr == OFS_DATA) && have;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       dev_addr <= '0;
        else if (bus_rst) dev_addr <= '0;
        else if (wr_addr) dev_addr <= AW'(csr_wdata);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     irq_en <= 1'b0;
        else if (wr_en) irq_en <= csr_wdata[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       irq_pend <= 1'b0;
        else if (commit)  irq_pend <= 1'b1;
        else if (wr_pend) irq_pend <= 1'b0;
    end

    always_comb begin
        csr_rdata = '0;
        case (csr_addr)
            OFS_ADDR:   csr_rdata = RW'(dev_addr);
            OFS_STATUS: csr_rdata = RW'({have, last_ep, dev_addr});
            OFS_DATA:   csr_rdata = have ? RW'(head_data) : '0;
            OFS_IRQEN:  csr_rdata = RW'(irq_en);
            OFS_IRQPND: csr_rdata = RW'(irq_pend);
            default:    csr_rdata = '0;
        endcase
    end

    assign irq = irq_pend && irq_en;

endmodule

// File: rtl/setup_capture.sv
module setup_capture
    import setup_cap_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned EPW   = 4,
    localparam int unsigned PW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              usb_reset,
    input  logic              tok_setup,
    input  logic [EPW-1:0]    tok_ep,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_last,
    output logic              ack_o,
    input  logic [CSR_AW-1:0] csr_addr,
    input  logic              csr_wr,
    input  logic              csr_rd,
    input  logic [7:0]        csr_wdata,
    output logic [15:0]       csr_rdata,
    output logic              irq_o
);

    logic           fifo_clr, push, pop, flush, commit, committed;
    logic           fifo_empty, fifo_full, have;
    logic [PW-1:0]  fifo_level;
    logic [7:0]     head_data;
    logic [EPW-1:0] last_ep;
    logic [7:0]     dev_addr;
    logic           irq_en, irq_pend;

    // write count seen by the controller equals level while nothing is read
    setup_byte_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (fifo_clr),
        .push      (push),
        .push_data (rx_data),
        .pop       (pop),
        .head_data (head_data),
        .level     (fifo_level),
        .empty     (fifo_empty),
        .full      (fifo_full)
    );

    setup_cap_fsm #(.DEPTH(DEPTH), .EPW(EPW)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_rst     (usb_reset),
        .flush       (flush),
        .tok_setup   (tok_setup),
        .tok_ep      (tok_ep),
        .rx_valid    (rx_valid),
        .rx_last     (rx_last),
        .fifo_wcount (fifo_level),
        .fifo_full   (fifo_full),
        .fifo_clr    (fifo_clr),
        .push        (push),
        .ack         (ack_o),
        .commit      (commit),
        .committed   (committed),
        .last_ep     (last_ep)
    );

    assign have = committed && !fifo_empty;

    setup_cap_regs #(.EPW(EPW), .AW(8), .RW(16)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_rst   (usb_reset),
        .csr_addr  (csr_addr),
        .csr_wr    (csr_wr),
        .csr_rd    (csr_rd),
        .csr_wdata (csr_wdata),
        .commit    (commit),
        .have      (have),
        .last_ep   (last_ep),
        .head_data (head_data),
        .dev_addr  (dev_addr),
        .irq_en    (irq_en),
        .irq_pend  (irq_pend),
        .flush     (flush),
        .pop       (pop),
        .csr_rdata (csr_rdata),
        .irq       (irq_o)
    );

endmodule

// File: rtl/setup_cap_chk.sv
module setup_cap_chk
    import setup_cap_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned PW   = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              usb_reset,
    input logic              ack_o,
    input logic              commit,
    input logic [7:0]        dev_addr,
    input logic              irq_pend,
    input logic              csr_wr,
    input logic              csr_rd,
    input logic [CSR_AW-1:0] csr_addr,
    input logic [7:0]        csr_wdata,
    input logic              have,
    input logic [15:0]       csr_rdata,
    input logic [PW-1:0]     fifo_level
);

    // R1
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o);

    // R2
    addr_busreset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        usb_reset |=> (dev_addr == 8'd0));

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= PW'(DEPTH));

    // R8
    pend_on_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> irq_pend);

    // R8
    pend_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr && csr_addr == OFS_IRQPND && csr_wdata[0] && !commit) |=> !irq_pend);

    // R9
    empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rd && csr_addr == OFS_DATA && !have) |-> (csr_rdata == 16'd0));

    // R10
    reset_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        usb_reset |=> !have);

endmodule

bind setup_capture setup_cap_chk #(.DEPTH(DEPTH)) u_setup_cap_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .usb_reset  (usb_reset),
    .ack_o      (ack_o),
    .commit     (commit),
    .dev_addr   (dev_addr),
    .irq_pend   (irq_pend),
    .csr_wr     (csr_wr),
    .csr_rd     (csr_rd),
    .csr_addr   (csr_addr),
    .csr_wdata  (csr_wdata),
    .have       (have),
    .csr_rdata  (csr_rdata),
    .fifo_level (fifo_level)
);

// File: tb/test_setup_capture.sv
`timescale 1ns/1ps
module test_setup_capture;

    localparam time TCLK = 4ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        usb_reset = 1'b0;
    logic        tok_setup = 1'b0;
    logic [3:0]  tok_ep = '0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_last = 1'b0;
    logic        ack_o;
    logic [2:0]  csr_addr = '0;
    logic        csr_wr = 1'b0;
    logic        csr_rd = 1'b0;
    logic [7:0]  csr_wdata = '0;
    logic [15:0] csr_rdata;
    logic        irq_o;

    int unsigned checks = 0;
    int unsigned errors = 0;
    logic [7:0]  expq [$];
    bit          done = 1'b0;

    always #(TCLK/2) clk = ~clk;

    setup_capture i_setup_capture (
        .clk(clk), .rst_n(rst_n), .usb_reset(usb_reset),
        .tok_setup(tok_setup), .tok_ep(tok_ep),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
        .ack_o(ack_o), .csr_addr(csr_addr), .csr_wr(csr_wr), .csr_rd(csr_rd),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic csr_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        csr_addr = a; csr_wdata = d; csr_wr = 1'b1;
        @(posedge clk); #1;
        csr_wr = 1'b0;
    endtask

    task automatic csr_read(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        csr_addr = a; csr_rd = 1'b1;
        #1 d = csr_rdata;
        @(posedge clk); #1;
        csr_rd = 1'b0;
    endtask

    // driver: sends token, 8 payload bytes, 2 CRC bytes; checks handshake timing
    task automatic send_setup(input logic [3:0] ep, input logic [63:0] pkt);
        @(negedge clk);
        tok_setup = 1'b1; tok_ep = ep;
        @(posedge clk); #1;
        tok_setup = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_data  = (i < 8) ? pkt[8*i +: 8] : 8'hC0 + 8'(i);
            rx_last  = (i == 9);
            @(posedge clk); #1;
            rx_valid = 1'b0; rx_last = 1'b0;
            if (i < 9) chk("R1 no ack during packet", 32'(ack_o), 32'd0);
        end
        chk("R1 ack after last byte", 32'(ack_o), 32'd1);
        @(posedge clk); #1;
        chk("R1 ack one cycle", 32'(ack_o), 32'd0);
        expq.delete();
        for (int i = 0; i < 8; i++) expq.push_back(pkt[8*i +: 8]);
    endtask

    // monitor: pops bytes from the design and compares against the queue
    task automatic drain(input int n, input string req);
        logic [15:0] d;
        for (int i = 0; i < n; i++) begin
            csr_read(3'd3, d);
            if (expq.size() == 0) chk({req, " unexpected byte"}, 32'(d), 32'd0);
            else chk(req, 32'(d), 32'(expq.pop_front()));
        end
    endtask

    initial begin
        #(TCLK * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // reset state
        csr_read(3'd1, d); chk("R3 status after reset", 32'(d), 32'd0);
        chk("R8 irq after reset", 32'(irq_o), 32'd0);

        // address register
        csr_write(3'd0, 8'h2A);
        csr_read(3'd0, d); chk("R2 address readback", 32'(d), 32'h2A);

        // first packet on endpoint 0 with interrupt enabled
        csr_write(3'd4, 8'h01);
        send_setup(4'd0, 64'h0040_0000_0100_0680);
        chk("R8 irq after commit", 32'(irq_o), 32'd1);
        csr_read(3'd1, d); chk("R3 status have/ep/addr", 32'(d), 32'h102A);
        drain(7, "R4 byte order");
        csr_read(3'd1, d); chk("R5 have before last byte", 32'(d[12]), 32'd1);
        drain(1, "R4 byte order");
        csr_read(3'd1, d); chk("R5 have falls after eight reads", 32'(d[12]), 32'd0);
        csr_read(3'd3, d); chk("R9 empty read is zero", 32'(d), 32'd0);
        csr_read(3'd1, d); chk("R9 status after empty read", 32'(d), 32'h002A);

        // pending clear
        csr_write(3'd5, 8'h00);
        csr_read(3'd5, d); chk("R8 writing 0 keeps pending", 32'(d), 32'd1);
        csr_write(3'd5, 8'h01);
        chk("R8 w1c clears irq", 32'(irq_o), 32'd0);

        // replacement of unread data
        send_setup(4'd5, 64'h1111_2222_3333_4455);
        drain(3, "R4 partial read");
        send_setup(4'd3, 64'hF7E6_D5C4_B3A2_9180);
        csr_read(3'd1, d); chk("R6 endpoint of newest packet", 32'(d[11:8]), 32'd3);
        drain(8, "R6 newest packet bytes");
        csr_read(3'd1, d); chk("R6 no leftover", 32'(d[12]), 32'd0);

        // flush
        send_setup(4'd9, 64'h0102_0304_0506_0708);
        csr_write(3'd2, 8'h00);
        csr_read(3'd1, d); chk("R7 flush write of 0 ignored", 32'(d), 32'h192A);
        csr_write(3'd2, 8'h01);
        expq.delete();
        csr_read(3'd1, d); chk("R7 flush clears have and ep", 32'(d), 32'h002A);
        csr_read(3'd3, d); chk("R7 data after flush", 32'(d), 32'd0);

        // interrupt masked, then unmasked
        csr_write(3'd5, 8'h01);
        csr_write(3'd4, 8'h00);
        send_setup(4'd1, 64'hAAAA_BBBB_CCCC_DDDD);
        chk("R8 irq masked", 32'(irq_o), 32'd0);
        csr_read(3'd5, d); chk("R8 pending while masked", 32'(d), 32'd1);
        csr_write(3'd4, 8'h01);
        chk("R8 irq after enable", 32'(irq_o), 32'd1);
        drain(8, "R4 masked packet");
        csr_write(3'd5, 8'h01);

        // read during reception returns zero and loses nothing
        @(negedge clk); tok_setup = 1'b1; tok_ep = 4'd2;
        @(posedge clk); #1 tok_setup = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); rx_valid = 1'b1; rx_data = 8'h50 + 8'(i);
            @(posedge clk); #1 rx_valid = 1'b0;
        end
        csr_read(3'd3, d); chk("R9 read during capture", 32'(d), 32'd0);
        for (int i = 4; i < 10; i++) begin
            @(negedge clk); rx_valid = 1'b1; rx_data = 8'h50 + 8'(i); rx_last = (i == 9);
            @(posedge clk); #1 rx_valid = 1'b0; rx_last = 1'b0;
        end
        chk("R1 ack after interleaved read", 32'(ack_o), 32'd1);
        expq.delete();
        for (int i = 0; i < 8; i++) expq.push_back(8'h50 + 8'(i));
        @(posedge clk); #1;
        drain(8, "R9 bytes intact");
        csr_write(3'd5, 8'h01);

        // bus reset in mid packet
        @(negedge clk); tok_setup = 1'b1; tok_ep = 4'd7;
        @(posedge clk); #1 tok_setup = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); rx_valid = 1'b1; rx_data = 8'h99;
            @(posedge clk); #1 rx_valid = 1'b0;
        end
        @(negedge clk); usb_reset = 1'b1;
        @(posedge clk); #1 usb_reset = 1'b0;
        for (int i = 5; i < 10; i++) begin
            @(negedge clk); rx_valid = 1'b1; rx_data = 8'h99; rx_last = (i == 9);
            @(posedge clk); #1 rx_valid = 1'b0; rx_last = 1'b0;
            chk("R10 no ack after bus reset", 32'(ack_o), 32'd0);
        end
        @(posedge clk); #1;
        csr_read(3'd1, d); chk("R10 R2 status after bus reset", 32'(d), 32'd0);
        csr_read(3'd5, d); chk("R10 no pending after bus reset", 32'(d), 32'd0);

        // capture still works after bus reset
        send_setup(4'd15, 64'h0807_0605_0403_0201);
        csr_read(3'd1, d); chk("R3 status after recovery", 32'(d), 32'h1F00);
        drain(8, "R4 recovery packet");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule